// File: doc/BRIEF.md
# Multidrop Address-Wakeup Serial Receiver

This block is the receive side of a station on a shared serial multidrop line. A master first sends an address character and then a block of data characters meant for one of up to 256 stations. Address and data characters differ only in a flag bit that follows the eight payload bits. The station watches the line all the time, even while its data path is switched off. Each address character that arrives is stored and reported to the host through a sticky flag and an optional interrupt.

The host compares the stored address with its own station number. On a match it sends an enable command, and the data characters that follow appear one at a time on a byte output with a one-cycle strobe. When the block is complete the host sends a disable command, and the station goes back to watching for the next address. While the data path is off, data characters are dropped without leaving any trace. A frame whose stop bit is low is dropped and reported through a framing-error flag. The line is sampled with a 16x oversampling tick supplied from outside.

Top module: `mdrx_wake_rx`

## Requirements
- R1: A frame is one low start bit, eight payload bits sent least significant bit first, one flag bit (1 = address, 0 = data) and one stop bit. Each bit lasts 16 `os_tick` pulses and is sampled near its middle.
- R2: A frame with a good stop bit and the flag set to 1 loads its payload into `addr_q` and sets `addr_flag`, whatever the state of `rx_enabled`. It never produces `rx_valid`.
- R3: `irq` is high exactly when `addr_flag` and `irq_en` are both high.
- R4: A one-cycle pulse on `addr_ack` clears `addr_flag`. If an address is stored in the same cycle as an acknowledge, the flag ends up set.
- R5: A frame with a good stop bit and the flag set to 0, received while `rx_enabled` is high, puts its payload on `rx_data` and raises `rx_valid` for exactly one cycle. Characters are delivered in arrival order.
- R6: A data frame received while `rx_enabled` is low produces no `rx_valid` and changes neither `addr_flag` nor `ferr_flag`.
- R7: A frame whose stop bit samples low sets `ferr_flag`, leaves `addr_q` and `addr_flag` unchanged and produces no `rx_valid`, whether it was an address or a data frame. A pulse on `ferr_ack` clears `ferr_flag`.
- R8: `rx_en_cmd` sets `rx_enabled` and `rx_dis_cmd` clears it. When both are high in one cycle, the disable takes effect.
- R9: After reset, `addr_q` is 0 and `addr_flag`, `ferr_flag`, `rx_valid`, `rx_enabled` and `irq` are all low.
- R10: A low pulse on the idle line that has ended by the middle of the start bit (8 ticks after it is seen) starts no frame and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Oversampling tick, 16 per bit time |
| rx_en_cmd | input | 1 | Pulse: turn on data reception |
| rx_dis_cmd | input | 1 | Pulse: turn off data reception |
| irq_en | input | 1 | Interrupt enable for address arrival |
| addr_ack | input | 1 | Write-one-to-clear for `addr_flag` |
| ferr_ack | input | 1 | Write-one-to-clear for `ferr_flag` |
| addr_q | output | 8 | Most recently received address |
| addr_flag | output | 1 | Sticky: an address was received |
| ferr_flag | output | 1 | Sticky: a frame had a bad stop bit |
| rx_data | output | 8 | Last delivered data character |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_enabled | output | 1 | Data reception is on |
| irq | output | 1 | Address interrupt |

## Verification
Two collisions are covered. The first is storing a new address in the same cycle the host acknowledges the previous one. To provoke it, the bench holds `addr_ack` high for a whole address frame and counts the cycles `addr_flag` is high. Exactly one such cycle shows that the set won over the clear, and `addr_q` must hold the new address. The second is enable and disable commands arriving together. The bench judges it from the line side: after a simultaneous pulse, a following data frame must not reach the scoreboard.

// File: rtl/mdrx_pkg.sv
package mdrx_pkg;

    parameter int DATA_W  = 8;
    parameter int OSR_DEF = 16;

    typedef enum logic [1:0] {
        SM_IDLE,
        SM_START,
        SM_BITS
    } smp_state_e;

    typedef enum logic [1:0] {
        CK_BAD,
        CK_ADDR,
        CK_DATA
    } char_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] payload;
        logic              is_addr;
        logic              stop_ok;
    } rx_char_t;

    function automatic char_kind_e classify(rx_char_t c);
        if (!c.stop_ok) return CK_BAD;
        if (c.is_addr)  return CK_ADDR;
        return CK_DATA;
    endfunction

endpackage

// File: rtl/mdrx_sampler.sv
module mdrx_sampler
    import mdrx_pkg::*;
#(
    parameter int OSR = OSR_DEF
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_i,
    input  logic     tick_i,
    output rx_char_t char_o,
    output logic     done_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] STOP_IDX  = IDX_W'(DATA_W + 1);

    logic [1:0]       sync_q;
    logic             line_s;
    smp_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [DATA_W:0]  shreg;

    assign line_s = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], line_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SM_IDLE;
            cnt    <= '0;
            idx    <= '0;
            shreg  <= '0;
            done_o <= 1'b0;
            char_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (tick_i) begin
                unique case (state)
                    SM_IDLE: begin
                        if (!line_s) begin
                            state <= SM_START;
                            cnt   <= '0;
                        end
                    end
                    SM_START: begin
                        if (cnt == HALF_LAST) begin
                            cnt   <= '0;
                            idx   <= '0;
                            state <= line_s ? SM_IDLE : SM_BITS;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    SM_BITS: begin
                        if (cnt == FULL_LAST) begin
                            cnt <= '0;
                            if (idx == STOP_IDX) begin
                                done_o         <= 1'b1;
                                char_o.payload <= shreg[DATA_W-1:0];
                                char_o.is_addr <= shreg[DATA_W];
                                char_o.stop_ok <= line_s;
                                state          <= SM_IDLE;
                            end else begin
                                shreg <= {line_s, shreg[DATA_W:1]};
                                idx   <= idx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= SM_IDLE;
                endcase
            end
        end
    end

    assert_single_done_R1: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_start_confirm_R10: assert property (@(posedge clk) disable iff (rst)
        (state == SM_BITS && $past(state) == SM_START) |-> !$past(line_s));

endmodule

// File: rtl/mdrx_host_ctl.sv
module mdrx_host_ctl
    import mdrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_char_t          char_i,
    input  logic              done_i,
    input  logic              en_cmd,
    input  logic              dis_cmd,
    input  logic              irq_en,
    input  logic              addr_ack,
    input  logic              ferr_ack,
    output logic [DATA_W-1:0] addr_q,
    output logic              addr_flag,
    output logic              ferr_flag,
    output logic [DATA_W-1:0] data_q,
    output logic              valid,
    output logic              enabled,
    output logic              irq
);
    char_kind_e kind;

    assign kind = classify(char_i);
    assign irq  = addr_flag & irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            addr_flag <= 1'b0;
            ferr_flag <= 1'b0;
            data_q    <= '0;
            valid     <= 1'b0;
            enabled   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (dis_cmd)     enabled <= 1'b0;
            else if (en_cmd) enabled <= 1'b1;
            if (addr_ack) addr_flag <= 1'b0;
            if (ferr_ack) ferr_flag <= 1'b0;
            if (done_i) begin
                unique case (kind)
                    CK_BAD:  ferr_flag <= 1'b1;
                    CK_ADDR: begin
                        addr_q    <= char_i.payload;
                        addr_flag <= 1'b1;
                    end
                    CK_DATA: begin
                        if (enabled) begin
                            data_q <= char_i.payload;
                            valid  <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_valid_when_on_R5: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(enabled));

    assert_flag_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_flag) |-> $past(done_i && kind == CK_ADDR));

    assert_flag_clear_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(addr_flag) |-> $past(addr_ack));

    assert_ferr_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ferr_flag) |-> $past(done_i && kind == CK_BAD));

    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(done_i) |-> $stable(addr_q));

    assert_disable_wins_R8: assert property (@(posedge clk) disable iff (rst)
        $past(dis_cmd) |-> !enabled);

endmodule

// File: rtl/mdrx_wake_rx.sv
module mdrx_wake_rx
    import mdrx_pkg::*;
#(
    parameter int OSR = OSR_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              os_tick,
    input  logic              rx_en_cmd,
    input  logic              rx_dis_cmd,
    input  logic              irq_en,
    input  logic              addr_ack,
    input  logic              ferr_ack,
    output logic [DATA_W-1:0] addr_q,
    output logic              addr_flag,
    output logic              ferr_flag,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_enabled,
    output logic              irq
);
    rx_char_t char_w;
    logic     done_w;

    mdrx_sampler #(.OSR(OSR)) sampler_i (
        .clk    (clk),
        .rst    (rst),
        .line_i (rx_line),
        .tick_i (os_tick),
        .char_o (char_w),
        .done_o (done_w)
    );

    mdrx_host_ctl ctl_i (
        .clk       (clk),
        .rst       (rst),
        .char_i    (char_w),
        .done_i    (done_w),
        .en_cmd    (rx_en_cmd),
        .dis_cmd   (rx_dis_cmd),
        .irq_en    (irq_en),
        .addr_ack  (addr_ack),
        .ferr_ack  (ferr_ack),
        .addr_q    (addr_q),
        .addr_flag (addr_flag),
        .ferr_flag (ferr_flag),
        .data_q    (rx_data),
        .valid     (rx_valid),
        .enabled   (rx_enabled),
        .irq       (irq)
    );

endmodule

// File: tb/mdrx_wake_rx_tb_top.sv
module mdrx_wake_rx_tb_top;

    localparam int BITCLK = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic       rx_en_cmd = 1'b0;
    logic       rx_dis_cmd = 1'b0;
    logic       irq_en = 1'b0;
    logic       addr_ack = 1'b0;
    logic       ferr_ack = 1'b0;
    logic [7:0] addr_q;
    logic       addr_flag;
    logic       ferr_flag;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_enabled;
    logic       irq;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  en_mdl = 1'b0;
    bit  finished = 1'b0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    mdrx_wake_rx dut_i (
        .clk(clk), .rst(rst), .rx_line(rx_line), .os_tick(os_tick),
        .rx_en_cmd(rx_en_cmd), .rx_dis_cmd(rx_dis_cmd), .irq_en(irq_en),
        .addr_ack(addr_ack), .ferr_ack(ferr_ack), .addr_q(addr_q),
        .addr_flag(addr_flag), .ferr_flag(ferr_flag), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_enabled(rx_enabled), .irq(irq)
    );

    initial forever @(negedge clk) os_tick = ~os_tick;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor side of the scoreboard (R5, R6)
    initial forever begin
        @(negedge clk);
        if (rx_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected rx_valid", rx_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rx_data == e, "R5 delivered byte", rx_data, e);
            end
        end
    end

    // driver: one frame, R1 format; short_stop drives a low stop then recovers
    task automatic send_frame(input logic [7:0] d, input bit is_addr, input bit good_stop);
        if (good_stop && !is_addr && en_mdl) exp_q.push_back(d);
        rx_line = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = d[i];
            repeat (BITCLK) @(negedge clk);
        end
        rx_line = is_addr;
        repeat (BITCLK) @(negedge clk);
        rx_line = good_stop;
        repeat (good_stop ? BITCLK : 20) @(negedge clk);
        rx_line = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
    endtask

    task automatic pulse_en(input bit en, input bit dis);
        rx_en_cmd = en; rx_dis_cmd = dis;
        @(negedge clk);
        rx_en_cmd = 1'b0; rx_dis_cmd = 1'b0;
        if (dis) en_mdl = 1'b0; else if (en) en_mdl = 1'b1;
        @(negedge clk);
    endtask

    task automatic ack_addr();
        addr_ack = 1'b1; @(negedge clk); addr_ack = 1'b0; @(negedge clk);
    endtask

    task automatic ack_ferr();
        ferr_ack = 1'b1; @(negedge clk); ferr_ack = 1'b0; @(negedge clk);
    endtask

    initial begin
        int hi_cnt;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(addr_q == 8'h00 && !addr_flag && !ferr_flag && !rx_valid && !rx_enabled && !irq,
            "R9 reset state", {addr_flag, ferr_flag, rx_enabled, irq}, 0);

        // R2 address seen while disabled, R3 interrupt gating
        send_frame(8'h5A, 1'b1, 1'b1);
        chk(addr_q == 8'h5A, "R2 addr latched while disabled", addr_q, 8'h5A);
        chk(addr_flag == 1'b1, "R2 addr flag set", addr_flag, 1);
        chk(irq == 1'b0, "R3 irq masked", irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R3 irq enabled", irq, 1);

        // R4 acknowledge
        ack_addr();
        chk(!addr_flag && !irq, "R4 ack clears flag and irq", {addr_flag, irq}, 0);

        // R6 data while disabled is dropped
        send_frame(8'h33, 1'b0, 1'b1);
        chk(!addr_flag && !ferr_flag, "R6 no flag on dropped data", {addr_flag, ferr_flag}, 0);

        // R8 enable, R5 and R1 data delivery with varied bit patterns
        pulse_en(1'b1, 1'b0);
        chk(rx_enabled == 1'b1, "R8 enable", rx_enabled, 1);
        send_frame(8'hA5, 1'b0, 1'b1);
        send_frame(8'h01, 1'b0, 1'b1);
        send_frame(8'hFF, 1'b0, 1'b1);
        send_frame(8'h80, 1'b0, 1'b1);
        chk(rx_data == 8'h80, "R1 last byte LSB-first order", rx_data, 8'h80);

        // R2 address while enabled: latched, no data strobe
        send_frame(8'h12, 1'b1, 1'b1);
        chk(addr_q == 8'h12 && addr_flag, "R2 addr while enabled", addr_q, 8'h12);
        ack_addr();

        // R7 bad stop on data frame
        send_frame(8'h44, 1'b0, 1'b0);
        chk(ferr_flag == 1'b1, "R7 framing error on data", ferr_flag, 1);
        chk(addr_q == 8'h12 && !addr_flag, "R7 addr untouched", addr_q, 8'h12);
        ack_ferr();
        chk(ferr_flag == 1'b0, "R7 ferr ack", ferr_flag, 0);

        // R7 bad stop on address frame
        send_frame(8'h77, 1'b1, 1'b0);
        chk(addr_q == 8'h12 && !addr_flag, "R7 bad address dropped", addr_q, 8'h12);
        chk(ferr_flag == 1'b1, "R7 ferr on address", ferr_flag, 1);
        ack_ferr();

        // R10 short glitch on idle line
        rx_line = 1'b0;
        repeat (6) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
        chk(!addr_flag && !ferr_flag && addr_q == 8'h12, "R10 glitch ignored",
            {addr_flag, ferr_flag}, 0);
        send_frame(8'h6C, 1'b0, 1'b1);

        // R8 enable and disable together: disable wins, data dropped
        pulse_en(1'b1, 1'b1);
        chk(rx_enabled == 1'b0, "R8 disable wins", rx_enabled, 0);
        send_frame(8'h99, 1'b0, 1'b1);

        // R4 address arriving while ack is held: set wins for one cycle
        hi_cnt = 0;
        addr_ack = 1'b1;
        fork
            send_frame(8'h3C, 1'b1, 1'b1);
            begin
                repeat (450) begin
                    @(negedge clk);
                    if (addr_flag) hi_cnt++;
                end
            end
        join
        addr_ack = 1'b0;
        chk(hi_cnt == 1, "R4 set beats clear", hi_cnt, 1);
        chk(addr_q == 8'h3C, "R4 new address kept", addr_q, 8'h3C);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all expected bytes seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule